// File: doc/BRIEF.md
# Converter Result Read Port with Byte-Lane Swap

This block is the parallel read side of a data converter. It keeps the most recent conversion result in a register, which is reloaded only when the converter's busy flag goes from high to low. It puts that result on a 16-bit data bus in either straight binary or two's complement coding. The bus is split into two byte lanes, and each lane has its own output-enable signal. These enables stand in for real tri-state pads. Both enables are active only while the active-low chip select and the active-low read strobe are both low.

A swap input exchanges the two byte lanes. An 8-bit host can wire the swap line to an address bit and then fetch the whole word through one bus half, one byte per read. Both swap and coding select are combinational paths to the bus, so a host can change them between reads with no clock delay. A read that overlaps a conversion keeps seeing the previous result until the register reloads. A host that holds chip select and read low all the time sees the word change in the clock cycle after busy falls.

Top module: `rdport_result_port`

## Requirements
- R1: Both lane enables (`bus_oe_o[0]` for bits 7:0, `bus_oe_o[1]` for bits 15:8) are 1 only when `cs_n_i` and `rd_n_i` are both 0. While either one is 1, both enables are 0 and `data_o` is all zeros.
- R2: With `swap_i` = 0, `data_o[7:0]` carries bits 7:0 of the coded result and `data_o[15:8]` carries bits 15:8.
- R3: With `swap_i` = 1, `data_o[15:8]` carries bits 7:0 of the coded result and `data_o[7:0]` carries bits 15:8.
- R4: With `twos_sel_i` = 0, the coded result equals the stored straight-binary word. With `twos_sel_i` = 1, the coded result is that word with bit 15 inverted.
- R5: The result register takes `result_i` at the first rising clock edge where `busy_i` is sampled 0 after being sampled 1 at the edge before. At every other edge it holds its value, no matter how `result_i` changes.
- R6: Asynchronous reset clears the result register to 0x0000. After reset the bus therefore reads 0x0000 in binary coding and 0x8000 in two's complement coding.
- R7: A change on `swap_i`, `twos_sel_i`, `cs_n_i` or `rd_n_i` reaches `data_o` and `bus_oe_o` in the same cycle, with no register in between.
- R8: While a read stays active through a conversion, the bus shows the previous result up to the edge that detects busy falling. From the cycle after that edge, it shows the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Converter busy flag; a high-to-low change marks a new result |
| result_i | input | 16 | Straight-binary result from the converter |
| twos_sel_i | input | 1 | Output coding: 0 straight binary, 1 two's complement |
| swap_i | input | 1 | Byte-lane swap |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| data_o | output | 16 | Data bus value |
| bus_oe_o | output | 2 | Lane enables: bit 0 for bits 7:0, bit 1 for bits 15:8 |

## Verification
The assertions check on every cycle that the lane enables follow chip select and read, and that a disabled bus reads zero. They also check that the bus holds still when no busy fall was seen and the selects did not move, and that the word loaded after a busy fall reaches an unswapped, binary-coded bus. Only the bench's scenarios can show the lane order under swap and the bit-15 inversion against known values. The same goes for the old-then-new sequence seen by a continuous read, and for two-byte reads by an 8-bit host that toggles swap between reads.

// File: rtl/rdport_pkg.sv
package rdport_pkg;
  typedef enum logic {
    CODE_BINARY = 1'b0,
    CODE_TWOS   = 1'b1
  } code_sel_e;
endpackage

// File: rtl/rdport_edge.sv
module rdport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic done_o
);
  logic busy_q;
  logic busy_d;

  always_comb begin
    busy_d = busy_i;
    done_o = busy_q & ~busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end
endmodule

// File: rtl/rdport_hold.sv
module rdport_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load_i) word_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign q_o = word_q;
endmodule

// File: rtl/rdport_coder.sv
module rdport_coder
  import rdport_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] bin_i,
  input  code_sel_e    sel_i,
  output logic [W-1:0] word_o
);
  always_comb begin
    word_o = bin_i;
    if (sel_i == CODE_TWOS) word_o[W-1] = ~bin_i[W-1];
  end
endmodule

// File: rtl/rdport_lanes.sv
module rdport_lanes #(
  parameter int W      = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = W / BYTE_W
) (
  input  logic [W-1:0]     word_i,
  input  logic             swap_i,
  input  logic             en_i,
  output logic [W-1:0]     data_o,
  output logic [LANES-1:0] en_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int MIRROR = LANES - 1 - k;
    logic [BYTE_W-1:0] pick;
    always_comb begin
      pick = swap_i ? word_i[MIRROR*BYTE_W +: BYTE_W]
                    : word_i[k*BYTE_W +: BYTE_W];
    end
    assign data_o[k*BYTE_W +: BYTE_W] = en_i ? pick : '0;
    assign en_o[k] = en_i;
  end
endmodule

// File: rtl/rdport_result_port.sv
module rdport_result_port
  import rdport_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              twos_sel_i,
  input  logic              swap_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  bus_oe_o
);
  logic              done;
  logic [DATA_W-1:0] stored;
  logic [DATA_W-1:0] coded;
  logic              rd_en;
  code_sel_e         code_sel;

  assign rd_en    = ~cs_n_i & ~rd_n_i;
  assign code_sel = twos_sel_i ? CODE_TWOS : CODE_BINARY;

  rdport_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_i (busy_i),
    .done_o (done)
  );

  rdport_hold #(.W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (done),
    .d_i    (result_i),
    .q_o    (stored)
  );

  rdport_coder #(.W(DATA_W)) u_coder (
    .bin_i  (stored),
    .sel_i  (code_sel),
    .word_o (coded)
  );

  rdport_lanes #(.W(DATA_W), .BYTE_W(BYTE_W)) u_lanes (
    .word_i (coded),
    .swap_i (swap_i),
    .en_i   (rd_en),
    .data_o (data_o),
    .en_o   (bus_oe_o)
  );
endmodule

// File: rtl/rdport_result_port_chk.sv
module rdport_result_port_chk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  localparam int LANES = DATA_W / BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic [DATA_W-1:0] result_i,
  input logic              twos_sel_i,
  input logic              swap_i,
  input logic              cs_n_i,
  input logic              rd_n_i,
  input logic [DATA_W-1:0] data_o,
  input logic [LANES-1:0]  bus_oe_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_i || rd_n_i) |-> (bus_oe_o == '0 && data_o == '0));

  // R1
  oe_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_i && !rd_n_i) |-> (bus_oe_o == '1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && !($past(busy_i, 2) && !$past(busy_i)) &&
     $stable(swap_i) && $stable(twos_sel_i) && $stable(cs_n_i) && $stable(rd_n_i))
    |-> $stable(data_o));

  // R8
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd3 && $past(busy_i, 2) && !$past(busy_i) &&
     !cs_n_i && !rd_n_i && !swap_i && !twos_sel_i)
    |-> (data_o == $past(result_i)));
endmodule

bind rdport_result_port rdport_result_port_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .result_i   (result_i),
  .twos_sel_i (twos_sel_i),
  .swap_i     (swap_i),
  .cs_n_i     (cs_n_i),
  .rd_n_i     (rd_n_i),
  .data_o     (data_o),
  .bus_oe_o   (bus_oe_o)
);

// File: tb/rdport_result_port_tb_top.sv
module rdport_result_port_tb_top;
  logic        clk;
  logic        rst_n;
  logic        busy_i;
  logic [15:0] result_i;
  logic        twos_sel_i;
  logic        swap_i;
  logic        cs_n_i;
  logic        rd_n_i;
  logic [15:0] data_o;
  logic [1:0]  bus_oe_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [15:0] model_q;

  rdport_result_port dut_i (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .result_i(result_i),
    .twos_sel_i(twos_sel_i), .swap_i(swap_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .data_o(data_o), .bus_oe_o(bus_oe_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] expect_bus(logic [15:0] w, logic sw, logic tc);
    logic [15:0] c;
    c = w;
    if (tc) c[15] = ~c[15];
    return sw ? {c[7:0], c[15:8]} : c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bus(string req);
    #1;
    check(req, {14'd0, bus_oe_o, data_o}, {14'd0, 2'b11, expect_bus(model_q, swap_i, twos_sel_i)});
  endtask

  // busy high for two cycles, then falls with new data; register loads on next posedge
  task automatic convert(logic [15:0] val);
    @(negedge clk); busy_i = 1'b1; result_i = 16'hDEAD;
    @(negedge clk); @(negedge clk);
    busy_i = 1'b0; result_i = val;
    @(negedge clk);
    model_q = val;
  endtask

  task automatic t_reset;
    @(negedge clk); cs_n_i = 0; rd_n_i = 0;
    check_bus("R6 reset binary");
    twos_sel_i = 1; check_bus("R6 reset twos");
    check("R6 reset twos value", {16'd0, data_o}, {16'd0, 16'h8000});
    twos_sel_i = 0;
  endtask

  task automatic t_disable;
    convert(16'h1234);
    @(negedge clk); cs_n_i = 1; rd_n_i = 0; #1;
    check("R1 cs high", {14'd0, bus_oe_o, data_o}, 32'd0);
    cs_n_i = 0; rd_n_i = 1; #1;
    check("R1 rd high", {14'd0, bus_oe_o, data_o}, 32'd0);
    cs_n_i = 1; #1;
    check("R1 both high", {14'd0, bus_oe_o, data_o}, 32'd0);
    cs_n_i = 0; rd_n_i = 0;
    check_bus("R7 enable same cycle");
  endtask

  task automatic t_lanes;
    @(negedge clk); swap_i = 0; check_bus("R2 no swap");
    check("R2 value", {16'd0, data_o}, {16'd0, 16'h1234});
    swap_i = 1; check_bus("R3 swap");
    check("R3 value", {16'd0, data_o}, {16'd0, 16'h3412});
    swap_i = 0;
  endtask

  task automatic t_coding;
    convert(16'h0F80);
    @(negedge clk); twos_sel_i = 1; check_bus("R4 twos set msb");
    check("R4 value a", {16'd0, data_o}, {16'd0, 16'h8F80});
    convert(16'hFFFF);
    check_bus("R4 twos clear msb");
    twos_sel_i = 0; check_bus("R7 coding same cycle");
    swap_i = 1; twos_sel_i = 1; check_bus("R4 R3 combined");
    check("R4 value b", {16'd0, data_o}, {16'd0, 16'hFF7F});
    swap_i = 0; twos_sel_i = 0;
  endtask

  task automatic t_continuous;
    logic [15:0] old;
    old = model_q;
    @(negedge clk); busy_i = 1; result_i = 16'hAAAA;
    @(negedge clk); check_bus("R8 old during busy");
    busy_i = 0; result_i = 16'h5A01;
    #1; check("R8 old before edge", {16'd0, data_o}, {16'd0, old});
    @(negedge clk); model_q = 16'h5A01; check_bus("R8 new after fall");
  endtask

  task automatic t_ignore;
    @(negedge clk); result_i = 16'h0BAD;
    @(negedge clk); @(negedge clk); check_bus("R5 ignore without fall");
    busy_i = 1; result_i = 16'h7777;
    @(negedge clk); @(negedge clk); check_bus("R5 hold while busy");
    busy_i = 0;
    @(negedge clk); model_q = 16'h7777; check_bus("R5 load on fall");
  endtask

  task automatic t_byte_host;
    logic [7:0] lo, hi;
    convert(16'hC3A5);
    @(negedge clk); cs_n_i = 1; rd_n_i = 1; swap_i = 0;
    @(negedge clk); cs_n_i = 0; rd_n_i = 0; #1; lo = data_o[7:0];
    @(negedge clk); rd_n_i = 1; swap_i = 1;
    @(negedge clk); rd_n_i = 0; #1; hi = data_o[7:0];
    check("R3 byte host low half", {16'd0, hi, lo}, {16'd0, 16'hC3A5});
    @(negedge clk); swap_i = 1; #1; lo = data_o[15:8];
    swap_i = 0; #1; hi = data_o[15:8];
    check("R2 byte host high half", {16'd0, hi, lo}, {16'd0, 16'hC3A5});
  endtask

  initial begin
    rst_n = 0; busy_i = 0; result_i = 16'h0; twos_sel_i = 0; swap_i = 0;
    cs_n_i = 1; rd_n_i = 1; model_q = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_disable();
    t_lanes();
    t_coding();
    t_continuous();
    t_ignore();
    t_byte_host();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_errors++; n_checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule